// File: doc/BRIEF.md
# Coded sub-block flag scanner

This block walks a quantized square transform block stored in an external coefficient RAM. It cuts the block into 4x4 sub-blocks and marks each one that holds any nonzero coefficient. In the same pass it finds the last marked sub-block in diagonal scan order and the last nonzero coefficient inside that sub-block. From these it forms the block-level column and row of the last significant coefficient. The results are the inputs an entropy coder needs before it codes the coefficients of each sub-block.

A start pulse and a block size begin a scan. The block then issues one RAM read per cycle and visits every coefficient of the block exactly once, sub-block by sub-block. A single-cycle done pulse marks the end, and the results stay put until the next accepted start. The control is a four-state machine:
- IDLE waits and moves to SCAN on start.
- SCAN issues the reads and moves to DRAIN after the last read.
- DRAIN evaluates the final returned word and moves to FINISH.
- FINISH raises done and returns to IDLE.

Top module: `csbf_scan`

## Requirements
- R1: `size_sel` selects the block side: 0 gives 4, 1 gives 8, 2 gives 16 and 3 gives 32. Sub-blocks within the block, and coefficients within a sub-block, are taken in up-right diagonal order with positions written (x, y): index 0 is (0,0), 1 is (0,1), 2 is (1,0), 3 is (0,2), 4 is (1,1), 5 is (2,0), and so on to the far corner.
- R2: Coefficient (x, y) is read at `rd_addr = y*32 + x`, that is {y[4:0], x[4:0]}. Data returns on `rd_data` one cycle after `rd_en`. Only positions inside the selected block are read.
- R3: `csbf` bit i is 1 exactly when the sub-block with scan index i holds at least one nonzero coefficient. Bits at or above the block's sub-block count are 0.
- R4: `last_sb_idx` is the highest scan index whose `csbf` bit is 1.
- R5: Inside that sub-block, the last nonzero coefficient in diagonal order has in-sub-block position (lx, ly). Then `last_x` = 4*Xsb + lx and `last_y` = 4*Ysb + ly, where (Xsb, Ysb) are the sub-block's coordinates. For example, sub-block (3,1) with (1,3) gives (13,7).
- R6: For an all-zero block, `no_coeff` is 1, `csbf`, `last_sb_idx`, `last_x` and `last_y` are 0, and done still pulses. For any other block, `no_coeff` is 0.
- R7: `done` is high for exactly one cycle. It first reads high after the (16*S+1)-th rising edge following the edge that samples start, where S is the sub-block count.
- R8: A start pulse is ignored from the edge that accepts a start through the done cycle. Such a pulse changes neither the latency nor the results.
- R9: `csbf`, `last_sb_idx`, `last_x`, `last_y` and `no_coeff` hold their values from the done pulse until the next accepted start, whatever `rd_data` does.
- R10: After reset, `done` and `rd_en` are 0, `csbf` and the last-position outputs are 0, and `no_coeff` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (taken in IDLE only) |
| size_sel | input | 2 | Block side select, 4 << size_sel |
| rd_en | output | 1 | Coefficient RAM read strobe |
| rd_addr | output | 10 | Coefficient RAM address {y, x} |
| rd_data | input | 16 | Signed coefficient, one cycle after rd_en |
| csbf | output | 64 | Coded flag per sub-block, bit = scan index |
| last_sb_idx | output | 6 | Scan index of last coded sub-block |
| last_x | output | 5 | Column of last significant coefficient |
| last_y | output | 5 | Row of last significant coefficient |
| no_coeff | output | 1 | Block holds no nonzero coefficient |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
Properties check the following on every cycle:
- the done pulse is one cycle wide;
- the results hold between done and the next start;
- an empty result carries an all-zero flag string;
- the reported last sub-block is the highest set flag;
- every read falls inside the selected block and none is issued while idle.

Only the bench's scenarios can show that the flags and the last coordinates match the stored coefficients in diagonal order, that the latency is exact for each size, and that a start pulse arriving mid-scan is truly ignored.

// File: rtl/csbf_scan_pkg.sv
package csbf_scan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_DRAIN,
        ST_FINISH
    } scan_state_t;
endpackage

// File: rtl/csbf_diag_step.sv
// Next position along an up-right diagonal walk over a (lim+1)-square grid.
module csbf_diag_step #(
    parameter int W = 2
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] lim,
    output logic [W-1:0] nx,
    output logic [W-1:0] ny,
    output logic         at_end
);
    logic [W:0] diag_next;

    always_comb begin
        diag_next = {1'b0, x} + {1'b0, y} + (W+1)'(1);
        at_end    = (x == lim) && (y == lim);
        if ((y == '0) || (x == lim)) begin
            if (diag_next <= {1'b0, lim}) begin
                nx = '0;
                ny = diag_next[W-1:0];
            end else begin
                ny = lim;
                nx = W'(diag_next - {1'b0, lim});
            end
        end else begin
            nx = x + W'(1);
            ny = y - W'(1);
        end
    end
endmodule

// File: rtl/csbf_sb_eval.sv
// Tracks, per sub-block, whether a nonzero was seen and where the latest one sat.
module csbf_sb_eval #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          vld,
    input  logic          last_c,
    input  logic          nz,
    input  logic [CW-1:0] cx,
    input  logic [CW-1:0] cy,
    output logic          sb_hit,
    output logic [CW-1:0] hit_x,
    output logic [CW-1:0] hit_y
);
    logic          seen_q;
    logic [CW-1:0] lx_q, ly_q;
    logic          take;

    always_comb begin
        take   = vld && nz;
        hit_x  = take ? cx : lx_q;
        hit_y  = take ? cy : ly_q;
        sb_hit = vld && last_c && (seen_q || nz);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            lx_q   <= '0;
            ly_q   <= '0;
        end else if (clr || (vld && last_c)) begin
            seen_q <= 1'b0;
        end else if (take) begin
            seen_q <= 1'b1;
            lx_q   <= cx;
            ly_q   <= cy;
        end
    end
endmodule

// File: rtl/csbf_scan.sv
module csbf_scan
    import csbf_scan_pkg::*;
#(
    parameter int MAX_LOG2_SIDE = 5,
    parameter int COEF_W        = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    input  logic [$clog2(MAX_LOG2_SIDE-1)-1:0]     size_sel,
    output logic                                   rd_en,
    output logic [2*MAX_LOG2_SIDE-1:0]             rd_addr,
    input  logic signed [COEF_W-1:0]               rd_data,
    output logic [(1<<(2*(MAX_LOG2_SIDE-2)))-1:0]  csbf,
    output logic [2*(MAX_LOG2_SIDE-2)-1:0]         last_sb_idx,
    output logic [MAX_LOG2_SIDE-1:0]               last_x,
    output logic [MAX_LOG2_SIDE-1:0]               last_y,
    output logic                                   no_coeff,
    output logic                                   done
);
    localparam int SB_W  = MAX_LOG2_SIDE - 2;
    localparam int SBI_W = 2 * SB_W;

    scan_state_t state, state_nx;

    logic [SB_W-1:0]  side_m1, sbx, sby, sb_nx, sb_ny;
    logic [SBI_W-1:0] sb_idx;
    logic [1:0]       cx, cy, c_nx, c_ny;
    logic [3:0]       c_idx;
    logic             sb_end, c_end_unused, last_issue;
    logic             found_q;

    logic             p_vld, p_last;
    logic [SBI_W-1:0] p_sb_idx;
    logic [SB_W-1:0]  p_sbx, p_sby;
    logic [1:0]       p_cx, p_cy;
    logic             sb_hit;
    logic [1:0]       hit_x, hit_y;
    logic             accept;

    csbf_diag_step #(.W(SB_W)) u_sb_step (
        .x(sbx), .y(sby), .lim(side_m1), .nx(sb_nx), .ny(sb_ny), .at_end(sb_end)
    );

    csbf_diag_step #(.W(2)) u_coef_step (
        .x(cx), .y(cy), .lim(2'd3), .nx(c_nx), .ny(c_ny), .at_end(c_end_unused)
    );

    csbf_sb_eval #(.CW(2)) u_eval (
        .clk(clk), .rst_n(rst_n), .clr(accept), .vld(p_vld), .last_c(p_last),
        .nz(rd_data != '0), .cx(p_cx), .cy(p_cy),
        .sb_hit(sb_hit), .hit_x(hit_x), .hit_y(hit_y)
    );

    assign accept     = (state == ST_IDLE) && start;
    assign last_issue = (c_idx == 4'd15) && sb_end;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_SCAN;
            ST_SCAN:   if (last_issue) state_nx = ST_DRAIN;
            ST_DRAIN:  state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_en    = (state == ST_SCAN);
        done     = (state == ST_FINISH);
        rd_addr  = {sby, cy, sbx, cx};
        no_coeff = !found_q;
    end

    // walk counters and read pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            side_m1 <= '0;
            sbx <= '0; sby <= '0; sb_idx <= '0;
            cx <= '0; cy <= '0; c_idx <= '0;
            p_vld <= 1'b0; p_last <= 1'b0; p_sb_idx <= '0;
            p_sbx <= '0; p_sby <= '0; p_cx <= '0; p_cy <= '0;
        end else begin
            p_vld    <= (state == ST_SCAN);
            p_last   <= (c_idx == 4'd15);
            p_sb_idx <= sb_idx;
            p_sbx    <= sbx;
            p_sby    <= sby;
            p_cx     <= cx;
            p_cy     <= cy;
            if (accept) begin
                side_m1 <= SB_W'((1 << size_sel) - 1);
                sbx <= '0; sby <= '0; sb_idx <= '0;
                cx <= '0; cy <= '0; c_idx <= '0;
            end else if (state == ST_SCAN) begin
                if (c_idx == 4'd15) begin
                    c_idx  <= '0;
                    cx     <= '0;
                    cy     <= '0;
                    sbx    <= sb_nx;
                    sby    <= sb_ny;
                    sb_idx <= sb_idx + SBI_W'(1);
                end else begin
                    c_idx <= c_idx + 4'd1;
                    cx    <= c_nx;
                    cy    <= c_ny;
                end
            end
        end
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            csbf        <= '0;
            last_sb_idx <= '0;
            last_x      <= '0;
            last_y      <= '0;
            found_q     <= 1'b0;
        end else if (sb_hit) begin
            csbf[p_sb_idx] <= 1'b1;
            last_sb_idx    <= p_sb_idx;
            last_x         <= {p_sbx, 2'b00} + MAX_LOG2_SIDE'(hit_x);
            last_y         <= {p_sby, 2'b00} + MAX_LOG2_SIDE'(hit_y);
            found_q        <= 1'b1;
        end
    end
endmodule

// File: rtl/csbf_scan_chk.sv
module csbf_scan_chk #(
    parameter int MAX_LOG2_SIDE = 5
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  start,
    input logic [$clog2(MAX_LOG2_SIDE-1)-1:0]    size_sel,
    input logic                                  rd_en,
    input logic [2*MAX_LOG2_SIDE-1:0]            rd_addr,
    input logic [(1<<(2*(MAX_LOG2_SIDE-2)))-1:0] csbf,
    input logic [2*(MAX_LOG2_SIDE-2)-1:0]        last_sb_idx,
    input logic [MAX_LOG2_SIDE-1:0]              last_x,
    input logic [MAX_LOG2_SIDE-1:0]              last_y,
    input logic                                  no_coeff,
    input logic                                  done
);
    localparam int L = MAX_LOG2_SIDE;

    logic                                busy_q, hold_q;
    logic [$clog2(MAX_LOG2_SIDE-1)-1:0]  size_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            hold_q <= 1'b1;
            size_q <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            hold_q <= 1'b0;
            size_q <= size_sel;
        end else if (done) begin
            busy_q <= 1'b0;
            hold_q <= 1'b1;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !start) |=> ($stable(csbf) && $stable(last_sb_idx) && $stable(last_x)
                                && $stable(last_y) && $stable(no_coeff))); // R9

    AST_EMPTY_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_coeff) |-> (csbf == '0)); // R6

    AST_LAST_IS_TOP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_coeff) |-> ((csbf >> last_sb_idx) == 1)); // R4

    AST_READ_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (((rd_addr[L-1:0] >> (2 + size_q)) == 0)
                   && ((rd_addr[2*L-1:L] >> (2 + size_q)) == 0))); // R2

    AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !rd_en); // R8
endmodule

bind csbf_scan csbf_scan_chk #(.MAX_LOG2_SIDE(MAX_LOG2_SIDE)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
    .rd_en(rd_en), .rd_addr(rd_addr), .csbf(csbf), .last_sb_idx(last_sb_idx),
    .last_x(last_x), .last_y(last_y), .no_coeff(no_coeff), .done(done)
);

// File: tb/tb_csbf_scan.sv
module tb_csbf_scan;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [1:0]         size_sel = '0;
    logic               rd_en;
    logic [9:0]         rd_addr;
    logic signed [15:0] rd_data = '0;
    logic [63:0]        csbf;
    logic [5:0]         last_sb_idx;
    logic [4:0]         last_x, last_y;
    logic               no_coeff, done;

    logic signed [15:0] mem [0:1023];
    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [63:0] exp_csbf;
    int exp_lsb, exp_lx, exp_ly;
    bit exp_none;

    always #5 clk = ~clk;

    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    csbf_scan dut (
        .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .csbf(csbf), .last_sb_idx(last_sb_idx), .last_x(last_x), .last_y(last_y),
        .no_coeff(no_coeff), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int diag_xy(input int n, input int idx);
        int k = 0;
        for (int d = 0; d < 2*n-1; d++)
            for (int y = n-1; y >= 0; y--) begin
                int x = d - y;
                if (y <= d && x < n) begin
                    if (k == idx) return x*256 + y;
                    k++;
                end
            end
        return -1;
    endfunction

    task automatic fill(input int sz, input int dens);
        int side = 4 << sz;
        for (int a = 0; a < 1024; a++) begin
            int x = a % 32;
            int y = a / 32;
            if (x < side && y < side) begin
                if (($urandom % 1000) < dens)
                    mem[a] = ($urandom % 2) ? 16'(1 + $urandom % 40) : -16'(1 + $urandom % 40);
                else
                    mem[a] = '0;
            end else begin
                mem[a] = 16'sh1234;
            end
        end
    endtask

    task automatic golden(input int sz);
        int n = 1 << sz;
        exp_csbf = '0; exp_lsb = 0; exp_lx = 0; exp_ly = 0; exp_none = 1'b1;
        for (int i = 0; i < n*n; i++) begin
            int p  = diag_xy(n, i);
            bit any = 1'b0;
            int lx = 0, ly = 0;
            for (int j = 0; j < 16; j++) begin
                int q  = diag_xy(4, j);
                int gx = (p / 256) * 4 + q / 256;
                int gy = (p % 256) * 4 + q % 256;
                if (mem[gy*32 + gx] != 0) begin
                    any = 1'b1; lx = gx; ly = gy;
                end
            end
            if (any) begin
                exp_csbf[i] = 1'b1; exp_lsb = i; exp_lx = lx; exp_ly = ly; exp_none = 1'b0;
            end
        end
    endtask

    task automatic run(input int sz, input bit poke);
        int cnt = 0;
        int lat = 16 * (1 << (2*sz)) + 1;
        golden(sz);
        @(negedge clk);
        size_sel = 2'(sz);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cnt < 5000) begin
            @(negedge clk);
            cnt++;
            start = (poke && cnt == 5);
        end
        start = 1'b0;
        check(cnt == lat, poke ? "R8 R7" : "R7", "done latency", 64'(cnt), 64'(lat));
        check(csbf == exp_csbf, "R1 R3", "flag string", csbf, exp_csbf);
        check(no_coeff == exp_none, "R6", "no_coeff", 64'(no_coeff), 64'(exp_none));
        check(last_sb_idx == 6'(exp_lsb), "R4", "last sub-block", 64'(last_sb_idx), 64'(exp_lsb));
        check(last_x == 5'(exp_lx), "R5 R2", "last_x", 64'(last_x), 64'(exp_lx));
        check(last_y == 5'(exp_ly), "R5 R2", "last_y", 64'(last_y), 64'(exp_ly));
        @(negedge clk);
        check(done == 1'b0, "R7", "done width", 64'(done), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] hold_csbf;
        logic [4:0]  hold_x, hold_y;
        void'($urandom(32'd20417));
        for (int a = 0; a < 1024; a++) mem[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 0 && rd_en == 0, "R10", "reset strobes", {62'd0, done, rd_en}, 64'd0);
        check(csbf == 0 && last_x == 0 && last_y == 0, "R10", "reset results", csbf, 64'd0);
        check(no_coeff == 1'b1, "R10", "reset no_coeff", 64'(no_coeff), 64'd1);

        // empty 32x32 block
        fill(3, 0);
        run(3, 1'b0);
        check(no_coeff && csbf == 0 && last_x == 0 && last_sb_idx == 0, "R6", "empty block", csbf, 64'd0);

        // single coefficient at (13,7) in 16x16: sub-block (3,1) is index 12
        fill(2, 0);
        mem[7*32 + 13] = -16'sd5;
        run(2, 1'b0);
        check(last_x == 5'd13 && last_y == 5'd7, "R5", "(13,7) example", {54'd0, last_x, last_y}, {54'd0, 5'd13, 5'd7});
        check(last_sb_idx == 6'd12 && csbf == 64'h1000, "R1 R3", "index of (3,1)", csbf, 64'h1000);

        // 4x4 corner and origin cases
        fill(0, 0);
        mem[3*32 + 3] = 16'sd1;
        mem[1*32 + 0] = 16'sd2;
        run(0, 1'b0);
        check(last_x == 5'd3 && last_y == 5'd3, "R5", "4x4 far corner", 64'(last_x), 64'd3);
        fill(0, 0);
        mem[0] = 16'sd9;
        mem[2] = 16'sd0;
        run(0, 1'b0);
        check(!no_coeff && last_x == 0 && last_y == 0 && csbf == 1, "R6", "origin only", csbf, 64'd1);

        // fully dense 32x32
        fill(3, 1000);
        run(3, 1'b0);
        check(csbf == '1 && last_sb_idx == 6'd63, "R3", "dense flags", csbf, '1);

        // random blocks, some with a start pulse mid-scan
        for (int t = 0; t < 24; t++) begin
            int sz = $urandom % 4;
            int dens;
            case ($urandom % 4)
                0: dens = 5;
                1: dens = 30;
                2: dens = 150;
                default: dens = 600;
            endcase
            fill(sz, dens);
            run(sz, (t % 3) == 1);
        end

        // hold after done while read data changes
        fill(2, 40);
        run(2, 1'b0);
        hold_csbf = csbf; hold_x = last_x; hold_y = last_y;
        for (int a = 0; a < 1024; a++) mem[a] = 16'sh0777;
        repeat (12) @(negedge clk);
        check(csbf == hold_csbf, "R9", "flags held", csbf, hold_csbf);
        check(last_x == hold_x && last_y == hold_y, "R9", "position held",
              {54'd0, last_x, last_y}, {54'd0, hold_x, hold_y});

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule